// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples 48 digital input lines, grouped into six 8-bit groups, and presents them to software as bytes in a small 8-byte port window. The window has a 3-bit address, read and write strobes, and an 8-bit data bus. Every input is passed through a two-stage synchronizer before it is used anywhere.

Each group has one enable bit. When a group is enabled and any of its lines changes, the block latches a sticky status bit for that group. A change in either direction counts. Any latched status raises the active-high interrupt request.

Software reads the status register at offset 7 to learn which groups changed. That read also acknowledges the interrupt. Writing 0 to offset 7 silences all groups.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Reads at offsets 0, 1, 2, 4, 5 and 6 return input groups 0 through 5 in that order. Group g holds inputs 8g to 8g+7, with the lowest-numbered input in bit 0.
- R2: A read at offset 3 returns 0x00.
- R3: Each input passes through two synchronizing flops. A change driven before clock edge a is not visible in a read taken before edge a+1, and is visible from edge a+1 on.
- R4: A write to offset 7 loads wdata bits 0 to 5 as the group enable mask, bit k for group k.
- R5: A read at offset 7 returns the group status in bits 0 to 5 and returns 0 in bit 7. Bit 6 is 0 while irq_o is high and 1 while irq_o is low.
- R6: An enabled group latches its status bit on a rising change of any of its lines. It also latches on a falling change.
- R7: A group whose enable bit is 0 never sets its status bit.
- R8: A write that clears a group's enable bit also clears that group's pending status.
- R9: A read at offset 7 clears the status bits once the read cycle ends. A change that latches in the same cycle as the read stays pending for the next read. Status bits are otherwise sticky.
- R10: irq_o is high exactly when any status bit in 0 to 5 is set.
- R11: After reset, all enables and status bits are 0, irq_o is low, and offset 7 reads 0x40.
- R12: Writes to offsets 0 to 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Byte offset in the window |
| rd_i | input | 1 | Read strobe; a read at offset 7 acknowledges |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| din_i | input | 48 | Asynchronous input lines |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a group change that latches in exactly the cycle in which the acknowledging read clears status. The latch point is set by the synchronizer depth, so the bench does the following:
- It first leaves another group pending.
- It toggles one input on a falling clock edge.
- It lets two rising edges pass, then opens the offset-7 read.

The read data must show only the older group. The following read must show only the new group.

Disabling a group while its status is pending is reached the same way, by following a latched change with an enable write. Reset is also applied in the middle of a run, to confirm that both the pending status and the enables are dropped.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned N_GRP    = 6;
  localparam int unsigned GRP_W    = 8;
  localparam int unsigned N_IN     = N_GRP * GRP_W;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd7;
  localparam logic [ADDR_W-1:0] HOLE_ADDR = 3'd3;

  // offsets 0..2 map to groups 0..2, offsets 4..6 to groups 3..5
  function automatic int unsigned addr_to_grp(logic [ADDR_W-1:0] a);
    return (a < HOLE_ADDR) ? int'(a) : int'(a) - 1;
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign chg_o  = s2_q ^ prev_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  assert_sync_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (sync_o == $past(din_i, 2)));
endmodule

// File: rtl/cos_grp_detect.sv
module cos_grp_detect #(
  parameter int unsigned N_GRP = 6,
  parameter int unsigned GRP_W = 8,
  localparam int unsigned W = N_GRP * GRP_W
) (
  input  logic [W-1:0]     chg_i,
  output logic [N_GRP-1:0] hit_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign hit_o[g] = |chg_i[g*GRP_W +: GRP_W];
  end
endmodule

// File: rtl/cos_status.sv
module cos_status #(
  parameter int unsigned N_GRP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_GRP-1:0] hit_i,
  input  logic             ack_i,
  input  logic             en_wr_i,
  input  logic [N_GRP-1:0] en_wdata_i,
  output logic [N_GRP-1:0] status_o,
  output logic             irq_o
);
  logic [N_GRP-1:0] en_q, stat_q, stat_d, keep, set;

  assign keep   = ack_i ? '0 : stat_q;
  assign set    = hit_i & en_q;
  assign stat_d = (keep | set) & (en_wr_i ? en_wdata_i : '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (en_wr_i) en_q <= en_wdata_i;
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |stat_q;

  assert_disabled_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~en_q) == '0);
  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !en_wr_i && (set == '0)) |=> (stat_q == '0));
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !en_wr_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  assert_latch_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr_i |=> ((stat_q & $past(hit_i & en_q)) == $past(hit_i & en_q)));
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_IN-1:0]   din_i,
  output logic              irq_o
);
  logic [N_IN-1:0]  sync, chg;
  logic [N_GRP-1:0] hit, status;
  logic             ack, en_wr, irq;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:N_GRP];
  assign ack   = rd_i && (addr_i == CTRL_ADDR);
  assign en_wr = wr_i && (addr_i == CTRL_ADDR);

  cos_sync #(.W(N_IN)) i_sync (
    .clk_i, .rst_ni, .din_i, .sync_o(sync), .chg_o(chg)
  );

  cos_grp_detect #(.N_GRP(N_GRP), .GRP_W(GRP_W)) i_detect (
    .chg_i(chg), .hit_o(hit)
  );

  cos_status #(.N_GRP(N_GRP)) i_status (
    .clk_i, .rst_ni, .hit_i(hit), .ack_i(ack), .en_wr_i(en_wr),
    .en_wdata_i(wdata_i[N_GRP-1:0]), .status_o(status), .irq_o(irq)
  );

  assign irq_o = irq;

  always_comb begin
    if (addr_i == CTRL_ADDR)
      rdata_o = {1'b0, ~irq, status};
    else if (addr_i == HOLE_ADDR)
      rdata_o = '0;
    else
      rdata_o = sync[addr_to_grp(addr_i)*GRP_W +: GRP_W];
  end

  assert_irq_matches_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == CTRL_ADDR) |-> (rdata_o[6] == !irq_o && !rdata_o[7]));
endmodule

// File: tb/test_cos_irq_ctrl.sv
module test_cos_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_ni = 0, rd = 0, wr = 0, irq;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [47:0] din = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_irq_ctrl i_cos_irq_ctrl (
    .clk_i(clk), .rst_ni, .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .din_i(din), .irq_o(irq)
  );

  localparam logic [47:0] PATS [4] = '{
    48'h0000_0000_0000, 48'hA5C3_1F80_7E01,
    48'hFFFF_FFFF_FFFF, 48'h1234_5678_9ABC
  };

  function automatic logic [7:0] exp_byte(logic [47:0] d, int a);
    case (a)
      0: return d[7:0];
      1: return d[15:8];
      2: return d[23:16];
      4: return d[31:24];
      5: return d[39:32];
      6: return d[47:40];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;

    // R11 reset state
    chk("R11 irq", {7'd0, irq}, 8'd0);
    rd_reg(3'd7, d); chk("R11 ctrl", d, 8'h40);

    // vector table: R1 R2, offset 7 idle with enables 0 (R5 R7)
    for (int p = 0; p < 4; p++) begin
      @(negedge clk) din = PATS[p];
      settle();
      for (int a = 0; a < 7; a++) begin
        rd_reg(a[2:0], d);
        chk(a == 3 ? "R2 hole" : "R1 byte", d, exp_byte(PATS[p], a));
      end
      rd_reg(3'd7, d); chk("R7 no status when disabled", d, 8'h40);
    end

    // R3 two-flop latency
    @(negedge clk) din = 48'h0; settle();
    @(negedge clk) din[7:0] = 8'h5A;
    @(posedge clk);
    rd_reg(3'd0, d); chk("R3 old before second edge", d, 8'h00);
    rd_reg(3'd0, d); chk("R3 new after second edge", d, 8'h5A);

    // R12 writes elsewhere ignored: enable not loaded
    for (int a = 0; a < 7; a++) wr_reg(a[2:0], 8'hFF);
    @(negedge clk) din = ~din; settle();
    chk("R12 irq", {7'd0, irq}, 8'd0);
    rd_reg(3'd7, d); chk("R12 ctrl", d, 8'h40);
    rd_reg(3'd0, d); chk("R12 input", d, ~8'h5A);

    // R4 R6 rising, R10 R5 R9
    @(negedge clk) din = 48'h0; settle();
    wr_reg(3'd7, 8'h3F);
    @(negedge clk) din[9] = 1'b1; settle();
    chk("R10 irq high", {7'd0, irq}, 8'd1);
    rd_reg(3'd7, d); chk("R6 rise R5 ctrl", d, 8'h02);
    chk("R9 irq cleared", {7'd0, irq}, 8'd0);
    rd_reg(3'd7, d); chk("R9 status cleared", d, 8'h40);

    // R6 falling, two groups
    @(negedge clk) begin din[9] = 1'b0; din[47] = 1'b1; end
    settle();
    rd_reg(3'd7, d); chk("R6 fall", d, 8'h22);

    // R4 R7 only group 0 enabled
    wr_reg(3'd7, 8'h01);
    @(negedge clk) din[20] = 1'b1; settle();
    chk("R7 irq", {7'd0, irq}, 8'd0);
    rd_reg(3'd7, d); chk("R7 ctrl", d, 8'h40);
    @(negedge clk) din[3] = 1'b1; settle();
    rd_reg(3'd7, d); chk("R4 group0 enabled", d, 8'h01);

    // R8 disable clears pending
    wr_reg(3'd7, 8'h3F);
    @(negedge clk) din[40] = 1'b1; settle();
    chk("R8 pending irq", {7'd0, irq}, 8'd1);
    wr_reg(3'd7, 8'h1F);
    chk("R8 irq dropped", {7'd0, irq}, 8'd0);
    rd_reg(3'd7, d); chk("R8 ctrl", d, 8'h40);

    // R9 change latching in the acknowledge cycle
    wr_reg(3'd7, 8'h3F);
    @(negedge clk) din[8] = ~din[8]; settle();
    @(negedge clk) din[0] = ~din[0];
    @(posedge clk); @(posedge clk);
    rd_reg(3'd7, d); chk("R9 first read", d, 8'h02);
    chk("R9 kept irq", {7'd0, irq}, 8'd1);
    rd_reg(3'd7, d); chk("R9 kept status", d, 8'h01);

    // R11 mid-run reset drops status and enables
    @(negedge clk) din[16] = ~din[16]; settle();
    @(negedge clk) rst_ni = 0;
    @(negedge clk) rst_ni = 1;
    chk("R11 irq after reset", {7'd0, irq}, 8'd0);
    rd_reg(3'd7, d); chk("R11 ctrl after reset", d, 8'h40);
    @(negedge clk) din[24] = ~din[24]; settle();
    rd_reg(3'd7, d); chk("R11 enables cleared", d, 8'h40);

    done = 1;
    summary();
  end
endmodule